// File: doc/BRIEF.md
# Converter Result Bus Read Stage

This block sits between the result register of a successive-approximation converter and a shared tri-state data bus. It keeps the last finished conversion result and, when a host read qualifies, produces the value and a per-line output enable for each of the bus lines. The pad drivers themselves are outside the block.

Two read formats are offered. In word mode every line is driven at once. In byte mode an address bit selects one of two bytes, both left-justified on the upper lines of an 8-bit host bus. The upper byte carries the top eight result bits. The lower byte carries the four low result bits followed by four zero bits, with the lower nibble lines meant to be strapped to the upper nibble lines outside the block. Because of that strapping, a change from one enabled pattern to another always passes through one cycle with nothing enabled.

All outputs are registered, so they follow the control inputs one clock later. A free-running stand-alone setup (enable and word mode held high, select and byte address held low) reads whenever read/convert is high and the converter is idle.

Top module: `conv_rdout`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with no read requested, `bus_oe_o` and `bus_o` are all zero.
- R2: A read qualifies only when `rc_i`=1, `busy_i`=0, `ce_i`=1 and `cs_n_i`=0. In the cycle after a sample where any of these fails, `bus_oe_o` is zero. Outputs reflect the inputs one clock after they are sampled.
- R3: A qualified read with `wide_i`=1 gives `bus_oe_o`=12'hFFF and `bus_o` equal to the held result, whatever the value of `sel_lo_i`.
- R4: A qualified read with `wide_i`=0 and `sel_lo_i`=0 gives `bus_oe_o`=12'hFF0. Lines 11:4 carry result bits 11:4 and lines 3:0 are 0.
- R5: A qualified read with `wide_i`=0 and `sel_lo_i`=1 gives `bus_oe_o`=12'h0FF. Lines 3:0 carry result bits 3:0, lines 7:4 drive 0, and lines 11:8 are 0.
- R6: In the cycle after `busy_i` is sampled high, `bus_oe_o` is zero.
- R7: The result is captured from `result_i` on the clock where `busy_i` is sampled low after being high in the previous sample. Changes on `result_i` at any other time do not reach `bus_o`.
- R8: When the requested pattern changes from one nonzero enable pattern to a different one, `bus_oe_o` is zero for exactly one cycle before the new pattern appears.
- R9: Any line whose enable is 0 carries 0 on `bus_o`.
- R10: With `ce_i`=1, `cs_n_i`=0, `wide_i`=1 and `sel_lo_i`=0 held, the full word is readable in every cycle after one where `rc_i`=1 and `busy_i`=0 were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Chip enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| rc_i | input | 1 | Read/convert: high requests a read |
| wide_i | input | 1 | Data mode: 1 word, 0 byte |
| sel_lo_i | input | 1 | Byte address: 0 upper byte, 1 lower byte |
| busy_i | input | 1 | Converter status, high while converting |
| result_i | input | 12 | Result word from the conversion engine |
| bus_o | output | 12 | Value for each data line |
| bus_oe_o | output | 12 | Output enable for each data line |

## Verification
The assertions assume that the control inputs and `busy_i` are synchronous to `clk` and are valid at every sampled edge once reset is released. They also assume that `result_i` is valid on the edge where `busy_i` falls. The bench changes every input only on the falling clock edge. It keeps `result_i` at the intended value whenever `busy_i` can drop, and it puts an idle cycle before each swept combination so that every point in the sweep starts from a disabled bus.

// File: rtl/conv_rdout_pkg.sv
package conv_rdout_pkg;
  // which set of data lines is currently driven
  typedef enum logic [1:0] {
    GRP_OFF  = 2'd0,
    GRP_WORD = 2'd1,
    GRP_HI   = 2'd2,
    GRP_LO   = 2'd3
  } grp_t;
endpackage

// File: rtl/rd_qualify.sv
module rd_qualify
  import conv_rdout_pkg::*;
(
  input  logic ce_i,
  input  logic cs_n_i,
  input  logic rc_i,
  input  logic wide_i,
  input  logic sel_lo_i,
  input  logic busy_i,
  output logic rd_ok_o,
  output grp_t grp_req_o
);
  always_comb begin
    rd_ok_o = rc_i && !busy_i && ce_i && !cs_n_i;
    if (!rd_ok_o)      grp_req_o = GRP_OFF;
    else if (wide_i)   grp_req_o = GRP_WORD;
    else if (sel_lo_i) grp_req_o = GRP_LO;
    else               grp_req_o = GRP_HI;
  end
endmodule

// File: rtl/result_hold.sv
module result_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy_i,
  input  logic [W-1:0] result_i,
  output logic [W-1:0] held_o,
  output logic         done_evt_o
);
  logic busy_q;

  assign done_evt_o = busy_q && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      held_o <= '0;
    end else begin
      busy_q <= busy_i;
      if (done_evt_o) held_o <= result_i;
    end
  end
endmodule

// File: rtl/bus_sequencer.sv
module bus_sequencer
  import conv_rdout_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  grp_t grp_req_i,
  output grp_t grp_o
);
  logic clash;

  // two different driven groups in a row are not allowed: insert a gap
  assign clash = (grp_o != GRP_OFF) && (grp_req_i != GRP_OFF) && (grp_req_i != grp_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     grp_o <= GRP_OFF;
    else if (clash) grp_o <= GRP_OFF;
    else            grp_o <= grp_req_i;
  end

  AST_BREAK_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o != GRP_OFF && $past(grp_o) != GRP_OFF) |-> grp_o == $past(grp_o)); // R8
endmodule

// File: rtl/conv_rdout.sv
module conv_rdout
  import conv_rdout_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             cs_n_i,
  input  logic             rc_i,
  input  logic             wide_i,
  input  logic             sel_lo_i,
  input  logic             busy_i,
  input  logic [RES_W-1:0] result_i,
  output logic [RES_W-1:0] bus_o,
  output logic [RES_W-1:0] bus_oe_o
);
  localparam int TAIL_W = RES_W - BYTE_W;
  localparam logic [RES_W-1:0] ALL_ONES = {RES_W{1'b1}};
  localparam logic [RES_W-1:0] HI_MASK  = ALL_ONES << TAIL_W;
  localparam logic [RES_W-1:0] LO_MASK  = ALL_ONES >> TAIL_W;
  localparam logic [RES_W-1:0] LSB_MASK = ALL_ONES >> BYTE_W;

  logic             rd_ok;
  logic             done_evt;
  grp_t             grp_req;
  grp_t             grp;
  logic [RES_W-1:0] held;

  function automatic logic [RES_W-1:0] line_oe(input grp_t g);
    case (g)
      GRP_WORD: line_oe = ALL_ONES;
      GRP_HI:   line_oe = HI_MASK;
      GRP_LO:   line_oe = LO_MASK;
      default:  line_oe = '0;
    endcase
  endfunction

  // lower byte: result LSBs on the lowest lines, trailing zeros above them
  function automatic logic [RES_W-1:0] line_val(input grp_t g, input logic [RES_W-1:0] w);
    case (g)
      GRP_WORD: line_val = w;
      GRP_HI:   line_val = w & HI_MASK;
      GRP_LO:   line_val = w & LSB_MASK;
      default:  line_val = '0;
    endcase
  endfunction

  rd_qualify u_qual (
    .ce_i      (ce_i),
    .cs_n_i    (cs_n_i),
    .rc_i      (rc_i),
    .wide_i    (wide_i),
    .sel_lo_i  (sel_lo_i),
    .busy_i    (busy_i),
    .rd_ok_o   (rd_ok),
    .grp_req_o (grp_req)
  );

  result_hold #(.W(RES_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .result_i   (result_i),
    .held_o     (held),
    .done_evt_o (done_evt)
  );

  bus_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_req_i (grp_req),
    .grp_o     (grp)
  );

  assign bus_oe_o = line_oe(grp);
  assign bus_o    = line_val(grp, held);

  AST_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rd_ok) |-> bus_oe_o == '0); // R2
  AST_IDLE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> bus_oe_o == '0); // R6
  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_o == '0 || bus_oe_o == ALL_ONES || bus_oe_o == HI_MASK || bus_oe_o == LO_MASK); // R3
  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_o & ~bus_oe_o) == '0); // R9
  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe_o == ALL_ONES && $past(bus_oe_o) == ALL_ONES && !$past(done_evt)) |-> $stable(bus_o)); // R7
endmodule

// File: tb/conv_rdout_test.sv
module conv_rdout_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_i, cs_n_i, rc_i, wide_i, sel_lo_i, busy_i;
  logic [11:0] result_i;
  logic [11:0] bus_o, bus_oe_o;
  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  conv_rdout uut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .cs_n_i(cs_n_i), .rc_i(rc_i),
    .wide_i(wide_i), .sel_lo_i(sel_lo_i), .busy_i(busy_i), .result_i(result_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // inputs are sampled at the rising edge, outputs are checked at the falling one
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic ce, input logic csn, input logic rc,
                       input logic wide, input logic sel, input logic busy);
    ce_i = ce; cs_n_i = csn; rc_i = rc; wide_i = wide; sel_lo_i = sel; busy_i = busy;
  endtask

  task automatic idle();
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step();
  endtask

  // a conversion: busy high with junk on result_i, then the value when busy drops
  task automatic convert(input logic [11:0] val);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
    result_i = ~val;
    step();
    step();
    result_i = val;
    busy_i = 1'b0;
    step();
  endtask

  function automatic logic [11:0] exp_oe(input logic rd, input logic wide, input logic sel);
    if (!rd)      return 12'h000;
    else if (wide) return 12'hFFF;
    else if (sel)  return 12'h0FF;
    else           return 12'hFF0;
  endfunction

  function automatic logic [11:0] exp_bus(input logic rd, input logic wide, input logic sel,
                                          input logic [11:0] r);
    if (!rd)       return 12'h000;
    else if (wide) return r;
    else if (sel)  return r % 16;
    else           return (r / 16) * 16;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] vals [2];
    vals[0] = 12'hA5C;
    vals[1] = 12'h3F1;
    rst_n = 1'b0;
    result_i = 12'h000;
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step();
    step();
    check("R1 oe in reset", bus_oe_o, 12'h000);
    check("R1 bus in reset", bus_o, 12'h000);
    rst_n = 1'b1;
    step();
    check("R1 oe after reset", bus_oe_o, 12'h000);

    // exhaustive sweep over the six control inputs for two results
    for (int v = 0; v < 2; v++) begin
      convert(vals[v]);
      for (int i = 0; i < 64; i++) begin
        logic ce, csn, rc, wide, sel, busy, rd;
        string tag;
        {ce, csn, rc, wide, sel, busy} = i[5:0];
        rd = rc && !busy && ce && !csn;
        idle();
        drive(ce, csn, rc, wide, sel, busy);
        step();
        if (busy)      tag = "R6";
        else if (!rd)  tag = "R2";
        else if (wide) tag = "R3";
        else if (sel)  tag = "R5";
        else           tag = "R4";
        check($sformatf("%s oe combo %0d", tag, i), bus_oe_o, exp_oe(rd, wide, sel));
        check($sformatf("%s/R9 bus combo %0d", tag, i), bus_o, exp_bus(rd, wide, sel, vals[v]));
      end
    end

    // R7: result_i changes outside a busy fall are not taken
    idle();
    convert(12'h123);
    result_i = 12'hFFF;
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    check("R7 held word", bus_o, 12'h123);
    result_i = 12'h0F0;
    step();
    check("R7 still held", bus_o, 12'h123);
    idle();
    convert(12'h8E7);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    step();
    check("R7 new result", bus_o, 12'h8E7);

    // R6: busy during a read closes the bus next cycle
    busy_i = 1'b1;
    step();
    check("R6 busy closes bus", bus_oe_o, 12'h000);
    busy_i = 1'b0;
    step();
    check("R2 reopen after busy", bus_oe_o, 12'hFFF);

    // R8: byte changes go through an empty cycle
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    check("R4 upper byte", bus_oe_o, 12'hFF0);
    step();
    check("R4 upper byte held", bus_o, 12'h8E0);
    sel_lo_i = 1'b1;
    step();
    check("R8 gap hi to lo", bus_oe_o, 12'h000);
    step();
    check("R8 lower byte oe", bus_oe_o, 12'h0FF);
    check("R5 lower byte data", bus_o, 12'h007);
    sel_lo_i = 1'b0;
    step();
    check("R8 gap lo to hi", bus_oe_o, 12'h000);
    step();
    check("R8 upper again", bus_oe_o, 12'hFF0);
    wide_i = 1'b1;
    step();
    check("R8 gap hi to word", bus_oe_o, 12'h000);
    step();
    check("R8 word after gap", bus_oe_o, 12'hFFF);
    sel_lo_i = 1'b1;
    step();
    check("R3 address ignored in word mode", bus_oe_o, 12'hFFF);

    // R10: stand-alone strapping, only rc and busy move
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step();
    check("R10 rc low", bus_oe_o, 12'h000);
    rc_i = 1'b1;
    step();
    check("R10 rc high oe", bus_oe_o, 12'hFFF);
    check("R10 rc high data", bus_o, 12'h8E7);
    result_i = 12'h456;
    busy_i = 1'b1;
    step();
    check("R10 converting", bus_oe_o, 12'h000);
    busy_i = 1'b0;
    step();
    check("R10 fresh word", bus_o, 12'h456);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule